// File: doc/BRIEF.md
# Pseudo-static RAM power-mode configuration controller

This block holds the 8-bit configuration word of a 1M x 16 pseudo-static RAM and turns it into the control state that the array and refresh logic need. A one-cycle load port writes the word. The controller also watches an active-low sleep pin with a cycle-counted timer. It reports whether page-mode reads are allowed, whether the part is in deep power down, which quarters of the array are refreshed and which can be reached, and two flags for a 20-bit word address presented on a lookup port: whether that address is refreshed, and whether it lies outside the reachable region.

The word can limit the array in two ways. Partial refresh keeps the whole address space reachable but refreshes only part of it, and it takes effect as soon as the word is written. Reduced size shrinks the reachable space, and a newly written reduced setting takes effect only on the next rising edge of the sleep pin. If the sleep pin is held low long enough while deep power down is permitted, every section stops refreshing. When the pin returns high, the configuration word is lost and reloads its default.

Top module: `psram_pwr_cfg`

## Requirements
- R1: After reset the word equals `CFG_DEFAULT` (0x10). In that state page reads are off, `access_mask` and `refresh_mask` are both 4'hF, `dpd_active` is 0 and no address is out of range.
- R2: `page_rd_en` equals word bit 7 whenever the part is not in deep power down.
- R3: With word bit 4 = 0, deep power down is entered on the clock edge that samples `sleep_n` low for the `HOLD_CYCLES`-th consecutive time. `dpd_active` rises after that edge and not earlier.
- R4: With word bit 4 = 1, deep power down is never entered, however long `sleep_n` stays low.
- R5: Any cycle with `sleep_n` high restarts the hold count from zero.
- R6: While `dpd_active` is 1, `refresh_mask`, `access_mask`, `page_rd_en`, `addr_refreshed` and `addr_out_of_range` are all 0.
- R7: The first edge that samples `sleep_n` high in deep power down clears `dpd_active` and reloads the default word, with full access and full refresh.
- R8: Load-port writes made during deep power down are ignored.
- R9: Word bit 4 = 1 with bit 3 = 0 selects partial refresh. The region is taken from the word immediately: quarter q = address bits 19:18. Bits 1:0 give the size: 11 keeps 1 quarter, 10 keeps 2, 01 keeps 3, 00 keeps all 4. Bit 2 = 0 keeps the lowest quarters and bit 2 = 1 keeps the highest. `access_mask` stays 4'hF.
- R10: Word bit 4 = 1 with bit 3 = 1 and bits 1:0 not equal to 00 selects reduced size. `access_mask` changes to that region only on a rising edge of `sleep_n`, and `refresh_mask` follows `access_mask`.
- R11: `addr_out_of_range` is 1 exactly when the quarter of `chk_addr` is outside `access_mask`. `addr_refreshed` equals `refresh_mask` at that quarter.
- R12: A write of any word that is not a reduced-size setting restores `access_mask` to 4'hF on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | Configuration word to load |
| sleep_n | input | 1 | Active-low sleep pin |
| chk_addr | input | 20 | Word address to classify |
| page_rd_en | output | 1 | Page-mode reads allowed |
| dpd_active | output | 1 | Deep power down in force; array contents invalid |
| refresh_mask | output | 4 | Per-quarter refresh enable |
| access_mask | output | 4 | Per-quarter reachable flag |
| addr_refreshed | output | 1 | The quarter of `chk_addr` is refreshed |
| addr_out_of_range | output | 1 | The quarter of `chk_addr` is not reachable |

## Verification
The assertions assume that `sleep_n` is already synchronous to `clk`, that `HOLD_CYCLES` is at least 2, and that a rising edge of `sleep_n` never coincides with a load-port write. If those collided, the write would win and the assertions on the held region would no longer describe a meaningful order. The stimulus drives every input on the falling clock edge. It changes `sleep_n` only in cycles without a write. Its hold windows sit just below, at, and well above the threshold, so that the edge where deep power down is entered is pinned exactly.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

   localparam int QUARTERS = 4;

   typedef struct packed {
      logic       page;
      logic [1:0] spare;
      logic       dpd_block;
      logic       rms_sel;
      logic       top_end;
      logic [1:0] size;
   } cfg_t;

   function automatic logic [QUARTERS-1:0] region_mask(input logic top_end,
                                                       input logic [1:0] size);
      logic [QUARTERS-1:0] m;
      int keep;
      case (size)
         2'b11:   keep = 1;
         2'b10:   keep = 2;
         2'b01:   keep = 3;
         default: keep = 4;
      endcase
      for (int q = 0; q < QUARTERS; q++) begin
         m[q] = top_end ? (q >= QUARTERS - keep) : (q < keep);
      end
      return m;
   endfunction

   function automatic logic is_rms(input cfg_t c);
      return c.dpd_block & c.rms_sel & (c.size != 2'b00);
   endfunction

   function automatic logic is_par(input cfg_t c);
      return c.dpd_block & ~c.rms_sel;
   endfunction

endpackage

// File: rtl/psram_dpd_timer.sv
module psram_dpd_timer
   #(parameter int HOLD_CYCLES = 1250)
   (input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    input  logic dpd_block,
    output logic dpd_active,
    output logic dpd_exit,
    output logic sleep_rise);

   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(HOLD_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

   generate
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] low_cnt;
   logic             sleep_q;
   logic             held_long;

   assign held_long  = ~sleep_n & (low_cnt >= CNT_LAST);
   assign dpd_exit   = dpd_active & sleep_n;
   assign sleep_rise = sleep_n & ~sleep_q & ~dpd_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt    <= '0;
         dpd_active <= 1'b0;
         sleep_q    <= 1'b1;
      end else begin
         sleep_q <= sleep_n;
         if (dpd_active) begin
            if (sleep_n) begin
               dpd_active <= 1'b0;
               low_cnt    <= '0;
            end
         end else begin
            if (held_long && !dpd_block) dpd_active <= 1'b1;
            if (sleep_n)                 low_cnt <= '0;
            else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
         end
      end
   end

   a_r4_blocked_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!dpd_active && dpd_block) |=> !dpd_active);
   a_r3_entry_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dpd_active) |-> $past(!sleep_n));
   a_r5_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n && !dpd_active) |=> (low_cnt == '0));
   a_r7_leave_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      (dpd_active && sleep_n) |=> !dpd_active);
   a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= CNT_MAX);

endmodule

// File: rtl/psram_cfg_reg.sv
module psram_cfg_reg
   import psram_cfg_pkg::*;
   #(parameter logic [7:0] CFG_DEFAULT = 8'h10)
   (input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic                dpd_active,
    input  logic                dpd_exit,
    input  logic                sleep_rise,
    output cfg_t                cfg,
    output logic [QUARTERS-1:0] rms_mask);

   localparam logic [QUARTERS-1:0] FULL = {QUARTERS{1'b1}};

   generate
      if (CFG_DEFAULT[1:0] != 2'b00) begin : g_bad_default
         $error("CFG_DEFAULT must select the full array");
      end
   endgenerate

   logic wr_ok;
   logic wr_full;
   cfg_t wr_cfg;

   assign wr_cfg  = cfg_t'(wr_data);
   assign wr_ok   = wr_en & ~dpd_active;
   assign wr_full = wr_ok & ~is_rms(wr_cfg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= cfg_t'(CFG_DEFAULT);
         rms_mask <= FULL;
      end else if (dpd_exit) begin
         cfg      <= cfg_t'(CFG_DEFAULT);
         rms_mask <= FULL;
      end else begin
         if (wr_ok) cfg <= wr_cfg;
         if (wr_full)
            rms_mask <= FULL;
         else if (sleep_rise && is_rms(cfg))
            rms_mask <= region_mask(cfg.top_end, cfg.size);
      end
   end

   a_r7_default_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
      dpd_exit |=> (cfg == cfg_t'(CFG_DEFAULT) && rms_mask == FULL));
   a_r8_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (dpd_active && !dpd_exit) |=> $stable(cfg));
   a_r10_region_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_rise && !wr_full && !dpd_exit) |=> $stable(rms_mask));
   a_r12_full_restore: assert property (@(posedge clk) disable iff (!rst_n)
      wr_full |=> (rms_mask == FULL));

endmodule

// File: rtl/psram_region_map.sv
module psram_region_map
   import psram_cfg_pkg::*;
   #(parameter int ADDR_W = 20)
   (input  cfg_t                cfg,
    input  logic [QUARTERS-1:0] rms_mask,
    input  logic                dpd_active,
    input  logic [ADDR_W-1:0]   addr,
    output logic                page_rd_en,
    output logic [QUARTERS-1:0] refresh_mask,
    output logic [QUARTERS-1:0] access_mask,
    output logic                addr_refreshed,
    output logic                addr_out_of_range);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   logic [1:0]          quarter;
   logic [QUARTERS-1:0] par_mask;
   logic                par_on;

   assign quarter  = addr[ADDR_W-1 -: 2];
   assign par_mask = region_mask(cfg.top_end, cfg.size);
   assign par_on   = is_par(cfg);

   for (genvar g = 0; g < QUARTERS; g++) begin : g_sect
      assign refresh_mask[g] = ~dpd_active & (par_on ? par_mask[g] : rms_mask[g]);
      assign access_mask[g]  = ~dpd_active & rms_mask[g];
   end

   assign page_rd_en        = cfg.page & ~dpd_active;
   assign addr_refreshed    = refresh_mask[quarter];
   assign addr_out_of_range = ~dpd_active & ~rms_mask[quarter];

   always_comb begin
      a_r6_dpd_quiet: assert (!dpd_active || (refresh_mask == '0 && !page_rd_en));
      a_r11_oor_not_refreshed: assert (!addr_out_of_range || !addr_refreshed);
   end

endmodule

// File: rtl/psram_pwr_cfg.sv
module psram_pwr_cfg
   import psram_cfg_pkg::*;
   #(parameter int         ADDR_W      = 20,
     parameter int         HOLD_CYCLES = 1250,
     parameter logic [7:0] CFG_DEFAULT = 8'h10)
   (input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              sleep_n,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              page_rd_en,
    output logic              dpd_active,
    output logic [3:0]        refresh_mask,
    output logic [3:0]        access_mask,
    output logic              addr_refreshed,
    output logic              addr_out_of_range);

   cfg_t                cfg;
   logic [QUARTERS-1:0] rms_mask;
   logic                dpd_exit;
   logic                sleep_rise;

   psram_dpd_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_n    (sleep_n),
      .dpd_block  (cfg.dpd_block),
      .dpd_active (dpd_active),
      .dpd_exit   (dpd_exit),
      .sleep_rise (sleep_rise));

   psram_cfg_reg #(.CFG_DEFAULT(CFG_DEFAULT)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_data    (cfg_wdata),
      .dpd_active (dpd_active),
      .dpd_exit   (dpd_exit),
      .sleep_rise (sleep_rise),
      .cfg        (cfg),
      .rms_mask   (rms_mask));

   psram_region_map #(.ADDR_W(ADDR_W)) u_map (
      .cfg               (cfg),
      .rms_mask          (rms_mask),
      .dpd_active        (dpd_active),
      .addr              (chk_addr),
      .page_rd_en        (page_rd_en),
      .refresh_mask      (refresh_mask),
      .access_mask       (access_mask),
      .addr_refreshed    (addr_refreshed),
      .addr_out_of_range (addr_out_of_range));

   a_r1_reset_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (access_mask == 4'hF && !dpd_active));

endmodule

// File: tb/psram_pwr_cfg_tb.sv
module psram_pwr_cfg_tb;

   localparam int HOLD = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic        sleep_n = 1'b1;
   logic [19:0] chk_addr = 20'h0;
   logic        page_rd_en, dpd_active, addr_refreshed, addr_out_of_range;
   logic [3:0]  refresh_mask, access_mask;

   psram_pwr_cfg #(.HOLD_CYCLES(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .sleep_n(sleep_n), .chk_addr(chk_addr), .page_rd_en(page_rd_en),
      .dpd_active(dpd_active), .refresh_mask(refresh_mask),
      .access_mask(access_mask), .addr_refreshed(addr_refreshed),
      .addr_out_of_range(addr_out_of_range));

   always #4 clk = ~clk;

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string tag = "R1";

   int m_cfg = 16, m_am = 15, m_cnt = 0, m_dpd = 0, m_prev = 1;
   bit started = 0;

   function automatic int mk_mask(int top, int sz);
      int keep, m;
      keep = (sz == 3) ? 1 : (sz == 2) ? 2 : (sz == 1) ? 3 : 4;
      m = 0;
      for (int q = 0; q < 4; q++)
         if (top != 0 ? (q >= 4 - keep) : (q < keep)) m = m | (1 << q);
      return m;
   endfunction

   function automatic bit rms_word(int w);
      return ((w >> 4) & 1) == 1 && ((w >> 3) & 1) == 1 && (w & 3) != 0;
   endfunction

   task automatic chk(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      int old_cfg, e_ref, q;
      bit rise, par;
      cyc++;
      if (!rst_n) begin
         m_cfg = 16; m_am = 15; m_cnt = 0; m_dpd = 0; m_prev = 1; started = 1;
      end else begin
         rise = sleep_n && m_prev == 0;
         old_cfg = m_cfg;
         if (m_dpd != 0) begin
            if (sleep_n) begin m_dpd = 0; m_cfg = 16; m_am = 15; m_cnt = 0; end
         end else begin
            if (cfg_we) m_cfg = cfg_wdata;
            if (cfg_we && !rms_word(cfg_wdata)) m_am = 15;
            else if (rise && rms_word(old_cfg))
               m_am = mk_mask((old_cfg >> 2) & 1, old_cfg & 3);
            if (!sleep_n && m_cnt >= HOLD - 1 && ((old_cfg >> 4) & 1) == 0) m_dpd = 1;
            if (sleep_n) m_cnt = 0;
            else if (m_cnt < HOLD) m_cnt++;
         end
         m_prev = sleep_n;
      end
      #2;
      if (started) begin
         q = chk_addr[19:18];
         par = ((m_cfg >> 4) & 1) == 1 && ((m_cfg >> 3) & 1) == 0;
         if (m_dpd != 0) e_ref = 0;
         else e_ref = par ? mk_mask((m_cfg >> 2) & 1, m_cfg & 3) : m_am;
         chk("dpd_active", dpd_active, m_dpd);
         chk("page_rd_en", page_rd_en, m_dpd != 0 ? 0 : (m_cfg >> 7) & 1);
         chk("access_mask", access_mask, m_dpd != 0 ? 0 : m_am);
         chk("refresh_mask", refresh_mask, e_ref);
         chk("addr_refreshed", addr_refreshed, (e_ref >> q) & 1);
         chk("addr_out_of_range", addr_out_of_range,
             m_dpd != 0 ? 0 : (((m_am >> q) & 1) == 0 ? 1 : 0));
      end
      if (cyc > 200000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   always @(negedge clk) chk_addr <= chk_addr + 20'h4_1A3B;

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int w);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'(w);
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic sleep_pulse(int n);
      @(negedge clk); sleep_n = 1'b0;
      idle(n);
      sleep_n = 1'b1;
   endtask

   initial begin
      tag = "R1"; idle(3); rst_n = 1'b1; idle(6);
      tag = "R2"; wr(8'h90); idle(4); wr(8'h10); idle(4);
      tag = "R9"; wr(8'h13); idle(8); wr(8'h16); idle(8);
      wr(8'h11); idle(8); wr(8'h15); idle(8); wr(8'h12); idle(8);
      tag = "R10"; wr(8'h1F); idle(8); sleep_pulse(3); idle(10);
      tag = "R11"; idle(12);
      tag = "R10"; wr(8'h1A); idle(8); sleep_pulse(2); idle(12);
      wr(8'h19); sleep_pulse(5); idle(10);
      tag = "R12"; wr(8'h10); idle(8); wr(8'h1D); sleep_pulse(2); idle(4); wr(8'h00); idle(6);
      tag = "R4"; wr(8'h10); sleep_pulse(HOLD + 10); idle(5);
      tag = "R5"; wr(8'h00); sleep_pulse(HOLD - 1); sleep_pulse(HOLD - 1); idle(5);
      tag = "R3"; wr(8'h80); sleep_pulse(HOLD + 1);
      idle(2);
      tag = "R6"; @(negedge clk); sleep_n = 1'b0; idle(HOLD + 6);
      tag = "R8"; cfg_we = 1'b1; cfg_wdata = 8'h93; idle(1); cfg_we = 1'b0; idle(4);
      tag = "R7"; sleep_n = 1'b1; idle(10);
      tag = "R3"; wr(8'h00); sleep_pulse(HOLD); idle(6);
      tag = "R2"; wr(8'h9B); idle(6);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule